// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Requests

This block sits between a bus-side register port and a serial audio port. It holds one queue of outgoing samples and one queue of incoming samples. Software or a DMA engine fills the transmit queue through a data register, and the serial side pulls from it one sample per `tx_pop` strobe. The serial side pushes captured samples into the receive queue, and the bus side drains it through the same data register. Each queue raises a DMA request when its fill level crosses a programmable threshold, so the DMA engine can move its bursts without polling.

The block detects two error conditions and keeps each in a sticky flag: a pop from an empty transmit queue (underrun) and a push into a full receive queue (overrun). On underrun it sends either zero or a repeat of the last sample, as a configuration bit selects. Flush strobes empty either queue. A build parameter selects whether the transmit flush strobe empties only the transmit queue or both queues. A loopback mode feeds popped transmit samples straight into the receive queue. A global enable gates all serial-side activity, and a soft-reset strobe restores every default.

Top module: `aud_fifo_dma`

The bus decodes `wr_addr`/`rd_addr` as 0 control, 1 configuration, 2 sample data, 3 status.

## Requirements
- R1: After reset, control reads 0, configuration reads 0x00007800 (transmit threshold 8 in bits 11:8, receive threshold 7 in bits 15:12, enable bit 0 clear), status reads 0, and both DMA requests and `irq` are low.
- R2: A bus write to address 2 pushes `wr_data` into the 32-entry transmit queue. A write while the queue is full is dropped, so the level stays at 32 and the first sample written stays at the head. The transmit level reads from status bits 13:8.
- R3: `tx_dma_req` is high exactly when enable (configuration bit 0), playback (control bit 1) and transmit DMA (control bit 14) are set and the transmit level is at or below the transmit threshold.
- R4: `rx_dma_req` is high exactly when enable, capture (control bit 0) and receive DMA (control bit 15) are set and the receive level (status bits 21:16) is at or above the receive threshold.
- R5: A `tx_pop` with enable and playback set puts the head sample on `tx_sample` in the following cycle, in write order. If the queue is empty, the pop sets the underrun flag (status bit 0) and `tx_sample` becomes 0, or becomes the last sample sent when configuration bit 6 is set.
- R6: An `rx_push` with enable and capture set stores `rx_sample`. A push into a full receive queue is dropped and sets the overrun flag (status bit 1). A bus read of address 2 with `rd_en` returns and removes the oldest sample.
- R7: Writing control with bit 8 set empties the transmit queue, and with bit 7 set empties the receive queue. With SHARED_FLUSH=1, bit 8 empties both queues. Neither bit is stored: both read back as 0.
- R8: The underrun and overrun flags stay set until a status write with a 1 in the matching bit (0 or 1). Writing 0 there leaves them set.
- R9: `irq` is the OR of underrun&ctrl[5], overrun&ctrl[6], transmit threshold met&ctrl[3], and receive threshold met&ctrl[4].
- R10: With enable clear, `tx_pop` and `rx_push` have no effect and both requests stay low. A configuration write with bit 3 set restores every R1 default and empties both queues.
- R11: Status bit 2 (busy) is high when enable is set and either playback is on with a non-empty transmit queue or capture is on with a non-empty receive queue.
- R12: With loopback (control bit 2) set, every sample that is successfully popped from the transmit queue is also pushed into the receive queue, and `rx_push` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Bus write address |
| wr_data | input | 32 | Bus write data |
| rd_en | input | 1 | Bus read strobe (pops the receive queue at address 2) |
| rd_addr | input | 2 | Bus read address |
| rd_data | output | 32 | Bus read data (combinational) |
| tx_pop | input | 1 | Serial side takes one transmit sample |
| tx_sample | output | DW | Sample presented to the serial side |
| rx_push | input | 1 | Serial side delivers one receive sample |
| rx_sample | input | DW | Incoming sample |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt |

## Verification
The hardest states to reach from the ports are the two full-queue boundaries. The receive overrun needs 32 accepted serial pushes followed by a 33rd push, with nothing draining the queue in between. The transmit drop needs 33 back-to-back bus writes. The bench reaches both with counted loops and then pops once to confirm that the head was preserved. The shared-flush variant runs as a second instance on identical stimulus, so a single flush write shows the receive queue surviving in one instance and emptying in the other.

// File: rtl/aud_pkg.sv
package aud_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CONF = 2'd1,
    A_DATA = 2'd2,
    A_STAT = 2'd3
  } aud_addr_e;

  // control bits
  localparam int B_CAP    = 0;
  localparam int B_PLAY   = 1;
  localparam int B_LOOP   = 2;
  localparam int B_IE_TSR = 3;
  localparam int B_IE_RSR = 4;
  localparam int B_IE_UR  = 5;
  localparam int B_IE_OR  = 6;
  localparam int B_RFL    = 7;
  localparam int B_TFL    = 8;
  localparam int B_TDMA   = 14;
  localparam int B_RDMA   = 15;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_C07F;

  // configuration bits
  localparam int C_EN   = 0;
  localparam int C_RST  = 3;
  localparam int C_LAST = 6;
  localparam int C_TTH  = 8;
  localparam int C_RTH  = 12;

  // status bits
  localparam int S_UR   = 0;
  localparam int S_OR   = 1;
  localparam int S_BUSY = 2;
  localparam int S_TLV  = 8;
  localparam int S_RLV  = 16;
endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
  parameter int DW    = 24,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end
endmodule

// File: rtl/aud_req_gen.sv
module aud_req_gen #(
  parameter int LW = 6,
  parameter int TW = 4
) (
  input  logic [LW-1:0] tx_lvl,
  input  logic [LW-1:0] rx_lvl,
  input  logic [TW-1:0] tx_thr,
  input  logic [TW-1:0] rx_thr,
  input  logic          tx_on,
  input  logic          rx_on,
  output logic          tx_hit,
  output logic          rx_hit
);
  function automatic logic needs_refill(input logic [LW-1:0] lvl, input logic [TW-1:0] thr);
    return lvl <= LW'(thr);
  endfunction

  function automatic logic needs_drain(input logic [LW-1:0] lvl, input logic [TW-1:0] thr);
    return lvl >= LW'(thr);
  endfunction

  assign tx_hit = tx_on && needs_refill(tx_lvl, tx_thr);
  assign rx_hit = rx_on && needs_drain(rx_lvl, rx_thr);
endmodule

// File: rtl/aud_fifo_dma.sv
module aud_fifo_dma
  import aud_pkg::*;
#(
  parameter int DW           = 24,
  parameter int DEPTH        = 32,
  parameter int TW           = 4,
  parameter int TX_THR_RST   = 8,
  parameter int RX_THR_RST   = 7,
  parameter bit SHARED_FLUSH = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  output logic [31:0]   rd_data,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_sample,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_sample,
  output logic          tx_dma_req,
  output logic          rx_dma_req,
  output logic          irq
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [31:0]   ctrl_q;
  logic          en_q, last_mode_q, ur_q, ov_q;
  logic [TW-1:0] tx_thr_q, rx_thr_q;
  logic [DW-1:0] last_smp_q, tx_sample_q;

  // named internal events
  logic wr_ctrl, wr_conf, wr_stat, soft_rst;
  logic tx_clr, rx_clr, ur_clr, ov_clr;
  logic tx_pop_evt, tx_take, ur_evt, rx_in_valid, ov_evt, rx_pop;
  logic [DW-1:0] tx_head, rx_head, rx_in_data;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_hit, rx_hit, busy;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_conf  = wr_en && (wr_addr == A_CONF);
  assign wr_stat  = wr_en && (wr_addr == A_STAT);
  assign soft_rst = wr_conf && wr_data[C_RST];
  assign ur_clr   = wr_stat && wr_data[S_UR];
  assign ov_clr   = wr_stat && wr_data[S_OR];

  assign tx_clr = soft_rst || (wr_ctrl && wr_data[B_TFL]);
  generate
    if (SHARED_FLUSH) begin : g_shared_flush
      assign rx_clr = soft_rst || (wr_ctrl && (wr_data[B_RFL] || wr_data[B_TFL]));
    end else begin : g_split_flush
      assign rx_clr = soft_rst || (wr_ctrl && wr_data[B_RFL]);
    end
  endgenerate

  assign tx_pop_evt  = en_q && ctrl_q[B_PLAY] && tx_pop;
  assign tx_take     = tx_pop_evt && !tx_empty;
  assign ur_evt      = tx_pop_evt && tx_empty;
  assign rx_in_valid = en_q && ctrl_q[B_CAP] && (ctrl_q[B_LOOP] ? tx_take : rx_push);
  assign rx_in_data  = ctrl_q[B_LOOP] ? tx_head : rx_sample;
  assign ov_evt      = rx_in_valid && rx_full;
  assign rx_pop      = rd_en && (rd_addr == A_DATA);

  aud_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(wr_en && (wr_addr == A_DATA)), .din(wr_data[DW-1:0]),
    .pop(tx_take), .dout(tx_head), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  aud_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_in_valid), .din(rx_in_data),
    .pop(rx_pop), .dout(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  aud_req_gen #(.LW(LW), .TW(TW)) u_req (
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_thr(tx_thr_q), .rx_thr(rx_thr_q),
    .tx_on(en_q && ctrl_q[B_PLAY]), .rx_on(en_q && ctrl_q[B_CAP]),
    .tx_hit(tx_hit), .rx_hit(rx_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      en_q        <= 1'b0;
      last_mode_q <= 1'b0;
      tx_thr_q    <= TW'(TX_THR_RST);
      rx_thr_q    <= TW'(RX_THR_RST);
      ur_q        <= 1'b0;
      ov_q        <= 1'b0;
      last_smp_q  <= '0;
      tx_sample_q <= '0;
    end else if (soft_rst) begin
      ctrl_q      <= '0;
      en_q        <= 1'b0;
      last_mode_q <= 1'b0;
      tx_thr_q    <= TW'(TX_THR_RST);
      rx_thr_q    <= TW'(RX_THR_RST);
      ur_q        <= 1'b0;
      ov_q        <= 1'b0;
      last_smp_q  <= '0;
      tx_sample_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data & CTRL_KEEP;
      if (wr_conf) begin
        en_q        <= wr_data[C_EN];
        last_mode_q <= wr_data[C_LAST];
        tx_thr_q    <= wr_data[C_TTH +: TW];
        rx_thr_q    <= wr_data[C_RTH +: TW];
      end
      ur_q <= ur_evt || (ur_q && !ur_clr);
      ov_q <= ov_evt || (ov_q && !ov_clr);
      if (tx_take) begin
        tx_sample_q <= tx_head;
        last_smp_q  <= tx_head;
      end else if (ur_evt) begin
        tx_sample_q <= last_mode_q ? last_smp_q : '0;
      end
    end
  end

  assign busy       = en_q && ((ctrl_q[B_PLAY] && !tx_empty) || (ctrl_q[B_CAP] && !rx_empty));
  assign tx_sample  = tx_sample_q;
  assign tx_dma_req = tx_hit && ctrl_q[B_TDMA];
  assign rx_dma_req = rx_hit && ctrl_q[B_RDMA];
  assign irq = (ur_q && ctrl_q[B_IE_UR]) || (ov_q && ctrl_q[B_IE_OR]) ||
               (tx_hit && ctrl_q[B_IE_TSR]) || (rx_hit && ctrl_q[B_IE_RSR]);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data = ctrl_q;
      A_CONF: begin
        rd_data[C_EN]         = en_q;
        rd_data[C_LAST]       = last_mode_q;
        rd_data[C_TTH +: TW]  = tx_thr_q;
        rd_data[C_RTH +: TW]  = rx_thr_q;
      end
      A_DATA: rd_data[DW-1:0] = rx_head;
      default: begin
        rd_data[S_UR]         = ur_q;
        rd_data[S_OR]         = ov_q;
        rd_data[S_BUSY]       = busy;
        rd_data[S_TLV +: LW]  = tx_lvl;
        rd_data[S_RLV +: LW]  = rx_lvl;
      end
    endcase
  end
endmodule

// File: rtl/aud_fifo_dma_chk.sv
module aud_fifo_dma_chk #(
  parameter int DW    = 24,
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic          last_mode_q,
  input logic          soft_rst,
  input logic          tx_clr,
  input logic          rx_clr,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic          ur_evt,
  input logic          ov_evt,
  input logic          ur_q,
  input logic          ov_q,
  input logic          ur_clr,
  input logic          ov_clr,
  input logic          tx_dma_req,
  input logic          rx_dma_req,
  input logic [DW-1:0] tx_sample
);
  assert_tx_level_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= LW'(DEPTH));

  assert_ur_sends_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ur_evt && !last_mode_q && !soft_rst) |=> (tx_sample == '0));

  assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_evt && !soft_rst) |=> ov_q);

  assert_flush_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (tx_lvl == '0));

  assert_flush_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_lvl == '0));

  assert_ur_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ur_q && !ur_clr && !soft_rst) |=> ur_q);

  assert_ov_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !ov_clr && !soft_rst) |=> ov_q);

  assert_no_req_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!tx_dma_req && !rx_dma_req));
endmodule

bind aud_fifo_dma aud_fifo_dma_chk #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .last_mode_q(last_mode_q),
  .soft_rst(soft_rst), .tx_clr(tx_clr), .rx_clr(rx_clr),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .ur_evt(ur_evt), .ov_evt(ov_evt),
  .ur_q(ur_q), .ov_q(ov_q), .ur_clr(ur_clr), .ov_clr(ov_clr),
  .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .tx_sample(tx_sample)
);

// File: tb/tb_aud_fifo_dma.sv
module tb_aud_fifo_dma;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, tx_pop = 1'b0, rx_push = 1'b0;
  logic [1:0]    wr_addr = '0, rd_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [DW-1:0] rx_sample = '0;
  logic [31:0]   rd_data, rd_data_s;
  logic [DW-1:0] tx_sample, tx_sample_s;
  logic          tx_dma_req, rx_dma_req, irq, txr_s, rxr_s, irq_s;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  aud_fifo_dma #(.SHARED_FLUSH(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tx_pop(tx_pop),
    .tx_sample(tx_sample), .rx_push(rx_push), .rx_sample(rx_sample),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .irq(irq)
  );

  aud_fifo_dma #(.SHARED_FLUSH(1'b1)) dut_shared (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_s), .tx_pop(tx_pop),
    .tx_sample(tx_sample_s), .rx_push(rx_push), .rx_sample(rx_sample),
    .tx_dma_req(txr_s), .rx_dma_req(rxr_s), .irq(irq_s)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic br(input logic [1:0] a, input logic pop, output logic [31:0] d, output logic [31:0] ds);
    @(negedge clk);
    rd_addr = a; rd_en = pop;
    #1 d = rd_data; ds = rd_data_s;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pop1();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic rxp(input logic [DW-1:0] d);
    @(negedge clk); rx_push = 1'b1; rx_sample = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic soft_reset();
    bw(2'd1, 32'h0000_0008);
  endtask

  task automatic t_reset();
    logic [31:0] d, ds;
    br(2'd0, 1'b0, d, ds); chk("R1 ctrl", d, 32'h0);
    br(2'd1, 1'b0, d, ds); chk("R1 conf", d, 32'h0000_7800);
    br(2'd3, 1'b0, d, ds); chk("R1 status", d, 32'h0);
    chk("R1 reqs/irq", {29'd0, tx_dma_req, rx_dma_req, irq}, 32'h0);
  endtask

  task automatic t_tx_req();
    bw(2'd1, 32'h0000_7801);
    bw(2'd0, 32'h0000_4002);
    chk("R3 empty queue requests", {31'd0, tx_dma_req}, 32'd1);
    for (int i = 0; i < 8; i++) bw(2'd2, 32'(i));
    chk("R3 level 8 at threshold", {31'd0, tx_dma_req}, 32'd1);
    bw(2'd2, 32'h9);
    chk("R3 level 9 above threshold", {31'd0, tx_dma_req}, 32'd0);
    bw(2'd2, 32'h0000_0000);
    bw(2'd1, 32'h0000_7800);
    chk("R10 request low when disabled", {31'd0, tx_dma_req}, 32'd0);
    soft_reset();
  endtask

  task automatic t_tx_full();
    logic [31:0] d, ds;
    bw(2'd1, 32'h0000_7801);
    bw(2'd0, 32'h0000_0002);
    for (int i = 0; i < 33; i++) bw(2'd2, 32'(100 + i));
    br(2'd3, 1'b0, d, ds); chk("R2 level capped at 32", {26'd0, d[13:8]}, 32'd32);
    pop1();
    chk("R2 head kept after dropped write", {8'd0, tx_sample}, 32'd100);
    soft_reset();
  endtask

  task automatic t_underrun();
    logic [31:0] d, ds;
    bw(2'd1, 32'h0000_7801);
    bw(2'd0, 32'h0000_0022);
    bw(2'd2, 32'h11); bw(2'd2, 32'h22); bw(2'd2, 32'h33);
    pop1(); chk("R5 order 1", {8'd0, tx_sample}, 32'h11);
    pop1(); chk("R5 order 2", {8'd0, tx_sample}, 32'h22);
    pop1(); chk("R5 order 3", {8'd0, tx_sample}, 32'h33);
    chk("R9 irq idle", {31'd0, irq}, 32'd0);
    pop1(); chk("R5 empty sends zero", {8'd0, tx_sample}, 32'h0);
    br(2'd3, 1'b0, d, ds); chk("R5 underrun flag", {31'd0, d[0]}, 32'd1);
    chk("R9 irq on underrun", {31'd0, irq}, 32'd1);
    bw(2'd3, 32'h0000_0002);
    br(2'd3, 1'b0, d, ds); chk("R8 zero write keeps flag", {31'd0, d[0]}, 32'd1);
    bw(2'd3, 32'h0000_0001);
    br(2'd3, 1'b0, d, ds); chk("R8 w1c clears flag", {31'd0, d[0]}, 32'd0);
    chk("R9 irq drops", {31'd0, irq}, 32'd0);
    bw(2'd1, 32'h0000_7841);
    pop1(); chk("R5 replay last sample", {8'd0, tx_sample}, 32'h33);
    soft_reset();
  endtask

  task automatic t_rx();
    logic [31:0] d, ds;
    bw(2'd1, 32'h0000_7801);
    bw(2'd0, 32'h0000_8001);
    for (int i = 0; i < 6; i++) rxp(DW'(32'h200 + i));
    chk("R4 level 6 below threshold", {31'd0, rx_dma_req}, 32'd0);
    rxp(DW'(32'h206));
    chk("R4 level 7 at threshold", {31'd0, rx_dma_req}, 32'd1);
    for (int i = 7; i < 32; i++) rxp(DW'(32'h200 + i));
    br(2'd3, 1'b0, d, ds);
    chk("R6 full no overrun", {26'd0, d[21:16], 4'd0, d[1:0]}, {26'd32, 6'd0});
    rxp(DW'(32'hBAD));
    br(2'd3, 1'b0, d, ds);
    chk("R6 overrun on full push", {26'd0, d[21:16], 4'd0, d[1:0]}, {26'd32, 6'd2});
    bw(2'd0, 32'h0000_8041);
    chk("R9 irq on overrun", {31'd0, irq}, 32'd1);
    br(2'd2, 1'b1, d, ds); chk("R6 oldest sample read", d, 32'h200);
    br(2'd3, 1'b0, d, ds); chk("R6 read pops", {26'd0, d[21:16]}, 32'd31);
    soft_reset();
  endtask

  task automatic t_flush();
    logic [31:0] d, ds;
    bw(2'd1, 32'h0000_7801);
    bw(2'd0, 32'h0000_0001);
    for (int i = 0; i < 3; i++) begin
      bw(2'd2, 32'(i));
      rxp(DW'(i));
    end
    bw(2'd0, 32'h0000_0101);
    br(2'd3, 1'b0, d, ds);
    chk("R7 tx flush split", {16'd0, 2'd0, d[21:16], 2'd0, d[13:8]}, {16'd0, 2'd0, 6'd3, 8'd0});
    chk("R7 tx flush shared", {16'd0, 2'd0, ds[21:16], 2'd0, ds[13:8]}, 32'd0);
    br(2'd0, 1'b0, d, ds); chk("R7 flush bit not stored", d, 32'h1);
    bw(2'd0, 32'h0000_0081);
    br(2'd3, 1'b0, d, ds); chk("R7 rx flush", {26'd0, d[21:16]}, 32'd0);
    soft_reset();
  endtask

  task automatic t_busy();
    logic [31:0] d, ds;
    bw(2'd1, 32'h0000_7801);
    bw(2'd0, 32'h0000_0002);
    br(2'd3, 1'b0, d, ds); chk("R11 idle when empty", {31'd0, d[2]}, 32'd0);
    bw(2'd2, 32'h1);
    br(2'd3, 1'b0, d, ds); chk("R11 busy with data", {31'd0, d[2]}, 32'd1);
    soft_reset();
  endtask

  task automatic t_loop();
    logic [31:0] d, ds;
    bw(2'd1, 32'h0000_7801);
    bw(2'd0, 32'h0000_0007);
    bw(2'd2, 32'h5A);
    pop1();
    br(2'd3, 1'b0, d, ds); chk("R12 looped into rx", {26'd0, d[21:16]}, 32'd1);
    br(2'd2, 1'b1, d, ds); chk("R12 looped value", d, 32'h5A);
    rxp(DW'(32'h99));
    br(2'd3, 1'b0, d, ds); chk("R12 rx_push ignored", {26'd0, d[21:16]}, 32'd0);
    soft_reset();
  endtask

  task automatic t_disabled();
    logic [31:0] d, ds;
    bw(2'd0, 32'h0000_0003);
    bw(2'd2, 32'h7); bw(2'd2, 32'h8);
    pop1();
    rxp(DW'(32'h44));
    br(2'd3, 1'b0, d, ds);
    chk("R10 pop/push ignored", {16'd0, 2'd0, d[21:16], 2'd0, d[13:8]}, {16'd0, 2'd0, 6'd0, 2'd0, 6'd2});
    chk("R10 sample unchanged", {8'd0, tx_sample}, 32'h0);
    bw(2'd1, 32'h0000_F0C1);
    soft_reset();
    br(2'd1, 1'b0, d, ds); chk("R10 soft reset conf", d, 32'h0000_7800);
    br(2'd3, 1'b0, d, ds); chk("R10 soft reset status", d, 32'h0);
    br(2'd0, 1'b0, d, ds); chk("R10 soft reset ctrl", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_req();
    t_tx_full();
    t_underrun();
    t_rx();
    t_flush();
    t_busy();
    t_loop();
    t_disabled();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule